// File: doc/BRIEF.md
# ATM Cell HEC Generator and Payload Scrambler

This block sits on the transmit path of a cell-based link and finishes 53-octet cells one byte at a time. It computes a header error check over octets 1 to 4 of each cell and places the result in octet 5. It scrambles the 48 payload octets, which are octets 6 to 53, so that user data cannot imitate line framing. Both functions apply in the same way to every cell, whether it is a user cell, a management cell inserted upstream or an idle fill cell.

The input and output are byte streams with a valid/ready handshake and a start-of-cell flag. A single output register sits between the two sides. It can accept a new byte in the same cycle that it hands its current byte downstream. Two static inputs select the functions: one enables HEC insertion and one enables scrambling. The scrambler is self-synchronizing. Its history runs from the payload of one cell straight into the payload of the next and does not include header octets.

Top module: `atm_cell_finisher`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: When `hec_en` is 1, output octet 5 equals the CRC-8 of octets 1 to 4 XOR 0x55. The CRC uses generator x^8+x^2+x+1 (0x07), an initial value of zero, and takes each byte MSB first. For example, header 00 00 00 01 gives 0x52.
- R3: When `hec_en` is 0, octet 5 leaves the block unchanged.
- R4: When `scr_en` is 1, every bit of payload octets 6 to 53 is taken MSB first and leaves as the input bit XOR the output bit sent 43 scrambled bits earlier. Scrambler history is all zeros after reset.
- R5: Scrambler history carries over from one cell's payload into the next cell's payload. Octets 1 to 5 never enter the history.
- R6: When `scr_en` is 0, payload octets leave the block unchanged and the scrambler history does not advance.
- R7: A byte accepted in cycle n appears on the output in cycle n+1. `out_soc` is 1 exactly on octet 1 of a cell.
- R8: A byte accepted with `in_soc` high is octet 1, even in the middle of a cell. Without `in_soc`, the octet after octet 53 is counted as octet 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` and `out_soc` hold their values.
- R10: Header octets 1 to 4 leave the block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hec_en | input | 1 | Enables HEC insertion into octet 5 |
| scr_en | input | 1 | Enables payload scrambling |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input cell byte |
| in_soc | input | 1 | Input byte is octet 1 of a cell |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Finished cell byte |
| out_soc | output | 1 | Output byte is octet 1 of a cell |

## Verification
Two functions can fall in the same cycle. The output register can drain a byte downstream and capture the next one, while the scrambler updates its history on the last payload octet of a cell and the octet counter restarts on the next cell's first octet. The bench provokes this by sending cells back to back while `out_ready` follows a pseudo-random pattern, so stalls and releases happen at cell boundaries. Each output byte is judged against a reference model that keeps its own 64-bit bit history and its own polynomial long division. A scrambler slip or a lost byte at the boundary therefore shows up as a payload mismatch in the following cell.

// File: rtl/cellfin_pkg.sv
package cellfin_pkg;
  // One byte of a left-shifting CRC-8, MSB of the data byte first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/cellfin_pos.sv
module cellfin_pos #(
  parameter int CELL_OCTETS = 53,
  localparam int IW = $clog2(CELL_OCTETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          soc,
  output logic [IW-1:0] idx,
  output logic          first
);
  logic [IW-1:0] cnt_q;
  localparam logic [IW-1:0] LAST = IW'(CELL_OCTETS - 1);

  assign idx   = soc ? '0 : cnt_q;
  assign first = (idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R8: the counter never leaves the cell range
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/cellfin_hec.sv
module cellfin_hec #(
  parameter int           CELL_OCTETS = 53,
  parameter int           HDR_OCTETS  = 4,
  parameter logic [7:0]   POLY        = 8'h07,
  parameter logic [7:0]   COSET       = 8'h55,
  localparam int          IW          = $clog2(CELL_OCTETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    din,
  output logic [7:0]    hec
);
  import cellfin_pkg::*;
  localparam logic [IW-1:0] HDR = IW'(HDR_OCTETS);

  logic [7:0] crc_q;
  logic       hdr_step;

  assign hdr_step = step && (idx < HDR);
  assign hec      = crc_q ^ COSET;

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= '0;
    else if (hdr_step) crc_q <= crc8_step((idx == '0) ? 8'h00 : crc_q, din, POLY);
  end

  // R2: the CRC only moves on header octets
  assert_crc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx >= HDR) |=> $stable(crc_q));
endmodule

// File: rtl/cellfin_scr.sv
module cellfin_scr #(
  parameter int SCR_LEN = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       active,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_LEN-1:0] hist_q;
  logic [SCR_LEN-1:0] hist_n;
  logic [7:0]         scr_byte;
  logic               adv;

  always_comb begin
    hist_n   = hist_q;
    scr_byte = '0;
    for (int i = 7; i >= 0; i--) begin
      scr_byte[i] = din[i] ^ hist_n[SCR_LEN-1];
      hist_n      = {hist_n[SCR_LEN-2:0], scr_byte[i]};
    end
  end

  assign adv  = step && active;
  assign dout = active ? scr_byte : din;

  always_ff @(posedge clk) begin
    if (!rst_n)   hist_q <= '0;
    else if (adv) hist_q <= hist_n;
  end

  // R5, R6: history frozen on header octets and when scrambling is off
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv) |=> $stable(hist_q));
  // R5: the newest history byte is the scrambled byte just emitted
  assert_hist_feed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> hist_q[7:0] == $past(dout));
endmodule

// File: rtl/atm_cell_finisher.sv
module atm_cell_finisher #(
  parameter int         CELL_OCTETS = 53,
  parameter int         HDR_OCTETS  = 4,
  parameter int         SCR_LEN     = 43,
  parameter logic [7:0] HEC_POLY    = 8'h07,
  parameter logic [7:0] HEC_COSET   = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hec_en,
  input  logic       scr_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_soc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_soc
);
  localparam int IW = $clog2(CELL_OCTETS);
  localparam logic [IW-1:0] HEC_IDX = IW'(HDR_OCTETS);

  logic          fire;
  logic [IW-1:0] idx;
  logic          first;
  logic          is_hec;
  logic          is_pay;
  logic [7:0]    hec_byte;
  logic [7:0]    scr_out;
  logic [7:0]    next_byte;
  logic          ov_q;
  logic [7:0]    od_q;
  logic          os_q;

  assign in_ready = !ov_q || out_ready;
  assign fire     = in_valid && in_ready;
  assign is_hec   = (idx == HEC_IDX);
  assign is_pay   = (idx > HEC_IDX);

  cellfin_pos #(.CELL_OCTETS(CELL_OCTETS)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(fire), .soc(in_soc),
    .idx(idx), .first(first));

  cellfin_hec #(.CELL_OCTETS(CELL_OCTETS), .HDR_OCTETS(HDR_OCTETS),
                .POLY(HEC_POLY), .COSET(HEC_COSET)) u_hec (
    .clk(clk), .rst_n(rst_n), .step(fire), .idx(idx), .din(in_data),
    .hec(hec_byte));

  cellfin_scr #(.SCR_LEN(SCR_LEN)) u_scr (
    .clk(clk), .rst_n(rst_n), .step(fire), .active(is_pay && scr_en),
    .din(in_data), .dout(scr_out));

  assign next_byte = (is_hec && hec_en) ? hec_byte : scr_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
      os_q <= 1'b0;
    end else begin
      if (in_ready) ov_q <= in_valid;
      if (fire) begin
        od_q <= next_byte;
        os_q <= first;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_soc   = os_q;

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));
  assert_stall_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  assert_soc_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_soc) |=> out_soc);
  assert_hdr_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && idx < HEC_IDX) |=> out_data == $past(in_data));
  assert_hec_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_hec && !hec_en) |=> out_data == $past(in_data));
  assert_hec_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_hec && hec_en) |=> out_data == $past(hec_byte));
  assert_pay_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_pay && !scr_en) |=> out_data == $past(in_data));
endmodule

// File: tb/atm_cell_finisher_tb.sv
module atm_cell_finisher_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hec_en = 1'b1, scr_en = 1'b1;
  logic       in_valid = 1'b0, in_soc = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_soc;
  logic [7:0] out_data;
  logic       out_ready;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  atm_cell_finisher u_dut (
    .clk(clk), .rst_n(rst_n), .hec_en(hec_en), .scr_en(scr_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_soc(in_soc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc));

  // downstream ready: fixed or pseudo-random
  logic        rnd_ready = 1'b0, rdy_fixed = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : rdy_fixed;

  // reference model state
  int          m_pos = 0;
  logic [31:0] m_hdr = '0;
  logic [63:0] m_hist = '0;
  bit          m_seen_pay = 0;
  logic [7:0]  exp_mem [2048];
  logic        exp_soc [2048];
  int          exp_tag [2048];
  int          wr = 0, rd = 0;

  function automatic string tagname(input int t);
    case (t)
      2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      10: return "R10"; default: return "R1";
    endcase
  endfunction

  // polynomial long division of header*x^8 by 0x107, then coset
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (r[b]) r[b -: 9] = r[b -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model one accepted byte, push expectation
  task automatic model_byte(input logic [7:0] d, input bit soc, input logic [8:0] ov);
    logic [7:0] e;
    int t;
    if (soc) m_pos = 0;
    if (m_pos < 4) begin
      e = d; t = 10; m_hdr = {m_hdr[23:0], d};
    end else if (m_pos == 4) begin
      e = hec_en ? ref_hec(m_hdr) : d; t = hec_en ? 2 : 3;
      if (ov[8]) e = ov[7:0];
    end else if (scr_en) begin
      for (int i = 7; i >= 0; i--) begin
        e[i] = d[i] ^ m_hist[42];
        m_hist = {m_hist[62:0], e[i]};
      end
      t = m_seen_pay ? 5 : 4;
      m_seen_pay = 1;
    end else begin
      e = d; t = 6;
    end
    exp_mem[wr] = e; exp_soc[wr] = (m_pos == 0); exp_tag[wr] = t; wr++;
    m_pos = (m_pos == 52) ? 0 : m_pos + 1;
  endtask

  task automatic send(input logic [7:0] d, input bit soc, input logic [8:0] ov);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_soc = soc;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    model_byte(d, soc, ov);
    @(posedge clk); #1;
    in_valid = 1'b0; in_soc = 1'b0;
  endtask

  task automatic send_cell(input logic [31:0] h, input logic [7:0] seed, input logic [8:0] ov);
    for (int k = 0; k < 4; k++) send(h[31-8*k -: 8], k == 0, 9'h0);
    send(seed ^ 8'hA5, 1'b0, ov);
    for (int k = 0; k < 48; k++) send(seed + 8'(k * 37), 1'b0, 9'h0);
  endtask

  task automatic drain();
    rnd_ready = 1'b0; rdy_fixed = 1'b1;
    while (rd != wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // output monitor
  always begin
    @(negedge clk); #5;
    if (rst_n && out_valid && out_ready) begin
      if (rd >= wr) check(1'b0, "R7 unexpected byte", {24'h0, out_data}, 32'h0);
      else begin
        check(out_data == exp_mem[rd], tagname(exp_tag[rd]), {24'h0, out_data}, {24'h0, exp_mem[rd]});
        check(out_soc == exp_soc[rd], "R8 soc", {31'h0, out_soc}, {31'h0, exp_soc[rd]});
        rd++;
      end
    end
  end

  // {hec_en, scr_en, header, seed, expected octet 5}
  localparam logic [49:0] VEC [6] = '{
    {1'b1, 1'b1, 32'h0000_0001, 8'h11, 8'h52},
    {1'b1, 1'b1, 32'h0000_0000, 8'h3A, 8'h55},
    {1'b1, 1'b0, 32'h0000_0002, 8'h7F, 8'h5B},
    {1'b0, 1'b1, 32'h0000_0004, 8'hC5, 8'h60},
    {1'b1, 1'b1, 32'h0000_0080, 8'h02, 8'hDC},
    {1'b0, 1'b0, 32'h0000_0001, 8'h99, 8'h3C}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R7: one-cycle latency and start marker
    send(8'h00, 1'b1, 9'h0);
    #1;
    check(out_valid && out_soc && out_data == 8'h00, "R7 latency", {out_valid, out_soc, out_data}, {2'b11, 8'h00});
    drain();

    // R2, R3, R4, R5, R6: table walk under random backpressure
    rnd_ready = 1'b1;
    foreach (VEC[i]) begin
      hec_en = VEC[i][49]; scr_en = VEC[i][48];
      check(ref_hec(32'h1) == 8'h52, "R2 model", {24'h0, ref_hec(32'h1)}, 32'h52);
      send_cell(VEC[i][47:16], VEC[i][15:8], {1'b1, VEC[i][7:0]});
    end
    drain();

    // R8: truncated cell restarted by a new start marker, then wrap without marker
    hec_en = 1'b1; scr_en = 1'b1;
    for (int k = 0; k < 10; k++) send(8'(k + 3), k == 0, 9'h0);
    send_cell(32'h0000_0002, 8'h40, 9'h0);
    for (int k = 0; k < 6; k++) send(8'(k * 11), 1'b0, 9'h0);
    drain();

    // R2: idle cell header gives 0x52 on octet 5
    rnd_ready = 1'b0; rdy_fixed = 1'b1;
    for (int k = 0; k < 4; k++) send(k == 3 ? 8'h01 : 8'h00, k == 0, 9'h0);
    send(8'hFF, 1'b0, 9'h0);
    #1;
    check(out_data == 8'h52, "R2 idle cell", {24'h0, out_data}, 32'h52);
    drain();

    // R9: stall holds output and blocks input
    rdy_fixed = 1'b0;
    send(8'h5A, 1'b0, 9'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #3;
      check(out_valid && !in_ready && out_data == exp_mem[wr-1], "R9 stall",
            {out_valid, in_ready, out_data}, {2'b10, exp_mem[wr-1]});
    end
    rdy_fixed = 1'b1;
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule